// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block models a byte-addressed serial EEPROM on the slave side of an SPI bus (mode 0). It samples the chip-select, serial-clock, hold and serial-data inputs on a fast system clock and drives one serial data output. Each frame starts with an 8-bit instruction. Array instructions are followed by a 16-bit address. The block then reads from or writes to an internal byte array, or reads or writes a small status register. That register holds a write-enable latch and a two-bit protection field.

An array write sends any number of data bytes after the address. Each complete byte is stored if the write-enable latch and the protection field allow it. The address then advances inside the current 128-byte page, so long bursts wrap back to the start of that page. An array read returns bytes on the serial output one after another, with the address running across the whole array. Raising chip select ends any frame at once. Dropping the hold input freezes the transfer without losing the serial-clock history.

Top module: `spi_ee_slave`

## Requirements
- R1: After reset, the serial output is 1, the status register reads 0x00 and every array byte reads 0x00.
- R2: While hold is high, chip select high ends the frame. The serial output returns to 1, any partly shifted byte is discarded, and the next low period of chip select starts a new 8-bit instruction.
- R3: Instructions are shifted in MSB first, one bit per serial-clock rising edge. 0x06 sets the write-enable latch and 0x04 clears it. Any code other than 0x01 to 0x06 leaves the block idle with the output at 1 until chip select rises.
- R4: Instruction 0x05 returns the status byte MSB first on the serial output. Bit 1 is the write-enable latch, bits 3:2 are the protection field and all other bits are 0. The same byte repeats for as long as the clock runs.
- R5: Instruction 0x01 followed by one data byte loads the protection field from bits 3:2 of that byte. The write-enable latch keeps its value.
- R6: Instructions 0x02 and 0x03 take a 16-bit address, MSB first. Only the low log2(DEPTH) bits are kept.
- R7: An array byte is stored only when the write-enable latch is 1 at the moment the eighth data bit arrives.
- R8: The protection field selects the read-only range. 00 protects nothing. 01 protects the top quarter of the array. 10 protects the top half. 11 protects the whole array.
- R9: After each data byte of an array write, only the address bits inside the 128-byte page are incremented, so a burst wraps within its page.
- R10: An array read presents bit 7 of the addressed byte after the first clock rising edge that follows the address. After every 8 bits it moves to the next address, wrapping from the last array byte to byte 0.
- R11: While hold is low, serial-clock edges and data are ignored. Releasing hold while the serial clock is high does not count as a rising edge.
- R12: The serial output changes only after a serial-clock rising edge or after chip select is deasserted. It is stable while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous to clk |
| sclk_i | input | 1 | Serial clock, asynchronous to clk |
| hold_n_i | input | 1 | Transfer pause, active low |
| sdi_i | input | 1 | Serial data into the device |
| sdo_o | output | 1 | Serial data out of the device, 1 when not reading |

## Verification
Assertions inside the RTL check four things on every system clock:
- A deasserted chip select leaves the output at 1, the bit counter at 0 and the decoder waiting for an instruction.
- Nothing moves while hold is low.
- A write burst never leaves its page.
- The array write strobe fires only with the latch set and never under full protection.

Other behaviour only the bench scenarios can show. These include whether the right bytes land at masked and page-wrapped addresses, each quarter boundary of the protection field, the status byte layout, the read wrap at the end of the array, and the absence of a false edge when hold is released with the clock high. The bench shows them by comparing read-back data with its own byte-array model.

// File: rtl/spi_ee_pkg.sv
// Shared types for the SPI EEPROM slave: frame phase and instruction codes.
// Assumes nothing beyond the 8-bit instruction width of the serial protocol.
package spi_ee_pkg;

    typedef enum logic [2:0] {
        ST_OPC,   // shifting in the instruction
        ST_ADDR,  // shifting in the 16-bit address
        ST_WR,    // shifting in data bytes (array or status)
        ST_RD,    // shifting out data bytes (array or status)
        ST_IDLE   // frame finished or unknown code: wait for chip select high
    } ee_state_t;

    localparam logic [7:0] OP_STAT_WR = 8'h01;
    localparam logic [7:0] OP_ARR_WR  = 8'h02;
    localparam logic [7:0] OP_ARR_RD  = 8'h03;
    localparam logic [7:0] OP_WEL_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_RD = 8'h05;
    localparam logic [7:0] OP_WEL_SET = 8'h06;

endpackage

// File: rtl/spi_ee_sync.sv
// Two-flop synchronizer bank for asynchronous pins.
// Each bit resets to its own idle level from INIT, so no false edge is seen
// when reset is released. Assumes inputs change slowly relative to clk.
module spi_ee_sync #(
    parameter int               WIDTH = 1,
    parameter logic [WIDTH-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [1:0] stg;

        // Move each pin through two flops toward the clk domain.
        always_ff @(posedge clk) begin
            if (!rst_n) stg <= {2{INIT[i]}};
            else        stg <= {stg[0], d[i]};
        end

        assign q[i] = stg[1];
    end

endmodule

// File: rtl/spi_ee_array.sv
// Byte storage for the EEPROM model: one synchronous write port and one
// combinational read port. Cleared by reset so that its contents are defined.
// Assumes DEPTH is a power of two.
module spi_ee_array #(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    // Clear on reset, otherwise store one byte per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/spi_ee_guard.sv
// Write permission decode: combines the write-enable latch with the quarter
// based protection field. Assumes the array has at least four bytes (AW >= 2).
module spi_ee_guard #(
    parameter int AW = 9
) (
    input  logic          wel,
    input  logic [1:0]    bp,
    input  logic [AW-1:0] addr,
    output logic          allow
);

    logic top_half;
    logic top_quarter;

    assign top_half    = addr[AW-1];
    assign top_quarter = addr[AW-1] & addr[AW-2];

    // Select the protected range from the two-bit field.
    always_comb begin
        case (bp)
            2'b01:   allow = wel & ~top_quarter;
            2'b10:   allow = wel & ~top_half;
            2'b11:   allow = 1'b0;
            default: allow = wel;
        endcase
    end

endmodule

// File: rtl/spi_ee_slave.sv
// SPI mode-0 serial EEPROM slave running on a fast system clock.
// Pins are synchronized and the serial clock's rising edge is found from the
// synchronized samples. One shared bit counter serves the instruction,
// address and data phases. Assumes sclk_i is at least four clk periods high
// and low, and that PAGE <= DEPTH, both powers of two, with DEPTH <= 65536.
module spi_ee_slave
    import spi_ee_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int PAGE  = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sclk_i,
    input  logic hold_n_i,
    input  logic sdi_i,
    output logic sdo_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(PAGE);

    logic       cs_s, sck_s, hold_s, sdi_s;
    logic       sck_d;
    logic       rise, step, abort;

    ee_state_t  state;
    logic [3:0] cnt;
    logic [7:0] opc, dbuf;
    logic [AW-1:0] addr;
    logic       wel;
    logic [1:0] bp;
    logic       sdo_q;

    logic [7:0]    opc_nx, dbuf_nx, stat_byte, rdata;
    logic [AW-1:0] addr_sh, rd_addr;
    logic          allow, mem_we;

    spi_ee_sync #(.WIDTH(4), .INIT(4'b1010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n_i, sclk_i, hold_n_i, sdi_i}),
        .q     ({cs_s, sck_s, hold_s, sdi_s})
    );

    spi_ee_guard #(.AW(AW)) u_guard (
        .wel   (wel),
        .bp    (bp),
        .addr  (addr),
        .allow (allow)
    );

    spi_ee_array #(.DEPTH(DEPTH)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (addr),
        .wdata (dbuf_nx),
        .raddr (rd_addr),
        .rdata (rdata)
    );

    assign rise      = sck_s & ~sck_d;
    assign step      = rise & hold_s & ~cs_s;
    assign abort     = hold_s & cs_s;
    assign opc_nx    = {opc[6:0], sdi_s};
    assign dbuf_nx   = {dbuf[6:0], sdi_s};
    assign addr_sh   = {addr[AW-2:0], sdi_s};
    assign stat_byte = {4'b0000, bp, wel, 1'b0};
    assign mem_we    = step && state == ST_WR && cnt == 4'd7 && !opc[0] && allow;

    // Read address: first byte right after the address, then the next byte.
    always_comb begin
        if (state == ST_ADDR) rd_addr = addr_sh;
        else                  rd_addr = AW'(addr + 1'b1);
    end

    // Serial clock history, tracked regardless of hold or chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Frame sequencer: instruction, address, data and status handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OPC;
            cnt   <= '0;
            opc   <= '0;
            dbuf  <= '0;
            addr  <= '0;
            wel   <= 1'b0;
            bp    <= 2'b00;
            sdo_q <= 1'b1;
        end else if (abort) begin
            state <= ST_OPC;
            cnt   <= '0;
            opc   <= '0;
            sdo_q <= 1'b1;
        end else if (step) begin
            case (state)
                ST_OPC: begin
                    opc <= opc_nx;
                    cnt <= cnt + 4'd1;
                    if (cnt == 4'd7) begin
                        cnt <= '0;
                        case (opc_nx)
                            OP_STAT_WR: begin dbuf <= '0; state <= ST_WR; end
                            OP_ARR_WR,
                            OP_ARR_RD:  begin addr <= '0; state <= ST_ADDR; end
                            OP_WEL_CLR: begin wel <= 1'b0; state <= ST_IDLE; end
                            OP_STAT_RD: begin dbuf <= stat_byte; state <= ST_RD; end
                            OP_WEL_SET: begin wel <= 1'b1; state <= ST_IDLE; end
                            default:    state <= ST_IDLE;
                        endcase
                    end
                end
                ST_ADDR: begin
                    addr <= addr_sh;
                    cnt  <= cnt + 4'd1;
                    if (cnt == 4'd15) begin
                        cnt   <= '0;
                        dbuf  <= opc[0] ? rdata : 8'h00;
                        state <= opc[0] ? ST_RD : ST_WR;
                    end
                end
                ST_WR: begin
                    dbuf <= dbuf_nx;
                    cnt  <= cnt + 4'd1;
                    if (cnt == 4'd7) begin
                        cnt <= '0;
                        if (opc[0]) begin
                            bp    <= dbuf_nx[3:2];
                            state <= ST_IDLE;
                        end else begin
                            dbuf <= '0;
                            addr <= {addr[AW-1:PW], PW'(addr[PW-1:0] + 1'b1)};
                        end
                    end
                end
                ST_RD: begin
                    sdo_q <= dbuf[~cnt[2:0]];
                    cnt   <= cnt + 4'd1;
                    if (cnt == 4'd7) begin
                        cnt <= '0;
                        if (opc == OP_ARR_RD) begin
                            addr <= rd_addr;
                            dbuf <= rdata;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sdo_o = sdo_q;

    // Chip select high leaves a clean frame start with the output released.
    assert_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold_s && cs_s) |-> (sdo_q && cnt == 4'd0 && state == ST_OPC));

    // Hold low freezes the sequencer and the output.
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!hold_s) |-> ($stable(state) && $stable(cnt) && $stable(sdo_q)));

    // A write burst stays inside the page it started in.
    assert_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR && $past(state) == ST_WR) |->
            addr[AW-1:PW] == $past(addr[AW-1:PW]));

    // The array strobe needs the latch and an array-write frame.
    assert_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wel && state == ST_WR && opc == OP_ARR_WR));

    // Full protection blocks every array store.
    assert_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && bp == 2'b11));

    // Output moves only on a qualified clock edge or a frame end.
    assert_out_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_q) |-> $past(step || abort));

    // Byte-phase counter never exceeds one byte outside the address phase.
    assert_cnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ADDR) |-> (cnt < 4'd8));

endmodule

// File: tb/spi_ee_slave_tb.sv
// Self-checking bench for spi_ee_slave with a behavioural byte-array model.
module spi_ee_slave_tb;

    localparam int DEPTH = 512;
    localparam int PAGE  = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, hold_n = 1'b1, sdi = 1'b0;
    logic sdo;

    int checks = 0;
    int fails  = 0;

    int ref_mem [DEPTH];
    int ref_wel = 0;
    int ref_bp  = 0;

    logic got_so, pre_so;

    always #4 clk = ~clk;

    spi_ee_slave #(.DEPTH(DEPTH), .PAGE(PAGE)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_i   (cs_n),
        .sclk_i   (sclk),
        .hold_n_i (hold_n),
        .sdi_i    (sdi),
        .sdo_o    (sdo)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        sdi = b;
        wait_n(4);
        pre_so = sdo;
        sclk = 1'b1;
        wait_n(8);
        got_so = sdo;
        sclk = 1'b0;
        wait_n(4);
    endtask

    task automatic send_byte(input int v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_addr(input int a);
        for (int i = 15; i >= 0; i--) send_bit(a[i]);
    endtask

    task automatic cs_lo();
        @(negedge clk);
        cs_n = 1'b0;
        wait_n(6);
    endtask

    task automatic cs_hi();
        @(negedge clk);
        cs_n = 1'b1;
        wait_n(6);
    endtask

    // Clock out one byte. A changed output before a rising edge breaks R12.
    task automatic read_byte(output int v);
        logic prev;
        int   bad;
        v = 0;
        bad = 0;
        prev = 1'b0;
        for (int b = 0; b < 8; b++) begin
            send_bit(1'b0);
            if (b > 0 && pre_so !== prev) bad = 1;
            prev = got_so;
            v = (v << 1) | int'(got_so);
        end
        chk("R12 output stable between edges", bad, 0);
    endtask

    function automatic int allowed(input int a);
        if (ref_wel == 0) return 0;
        case (ref_bp)
            1:       return (a < DEPTH * 3 / 4) ? 1 : 0;
            2:       return (a < DEPTH / 2) ? 1 : 0;
            3:       return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int stat_val();
        return (ref_bp << 2) | (ref_wel << 1);
    endfunction

    task automatic cmd(input int op);
        cs_lo();
        send_byte(op);
        cs_hi();
        if (op == 6) ref_wel = 1;
        if (op == 4) ref_wel = 0;
    endtask

    task automatic wr_stat(input int v);
        cs_lo();
        send_byte(1);
        send_byte(v);
        cs_hi();
        ref_bp = (v >> 2) & 3;
    endtask

    task automatic rd_stat(input int n, input string req);
        int v;
        cs_lo();
        send_byte(5);
        for (int i = 0; i < n; i++) begin
            read_byte(v);
            chk(req, v, stat_val());
        end
        cs_hi();
    endtask

    task automatic wr_arr(input int a16, input int q[$]);
        int a;
        cs_lo();
        send_byte(2);
        send_addr(a16);
        a = a16 & (DEPTH - 1);
        foreach (q[i]) begin
            send_byte(q[i]);
            if (allowed(a) != 0) ref_mem[a] = q[i] & 8'hFF;
            a = (a & ~(PAGE - 1)) | ((a + 1) & (PAGE - 1));
        end
        cs_hi();
    endtask

    task automatic rd_arr(input int a16, input int n, input string req);
        int v;
        int a;
        cs_lo();
        send_byte(3);
        send_addr(a16);
        a = a16 & (DEPTH - 1);
        for (int i = 0; i < n; i++) begin
            read_byte(v);
            chk(req, v, ref_mem[(a + i) % DEPTH]);
        end
        cs_hi();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int v;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 0;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(4);

        // R1: reset state.
        chk("R1 output high after reset", int'(sdo), 1);
        rd_stat(1, "R1 R4 status zero after reset");
        rd_arr(16'h0000, 3, "R1 array zero after reset");

        // R7: no write while latch clear.
        wr_arr(16'h0010, '{8'h11, 8'h22});
        rd_arr(16'h0010, 2, "R7 write rejected without latch");

        // R3 R4: set latch, status repeats.
        cmd(6);
        rd_stat(2, "R3 R4 latch set and status repeats");
        wr_arr(16'h0010, '{8'hA1, 8'hB2, 8'hC3});
        rd_arr(16'h0010, 3, "R7 write accepted with latch");

        // R9: page wrap.
        wr_arr(16'h007E, '{8'h5A, 8'h6B, 8'h7C, 8'h8D});
        rd_arr(16'h007E, 2, "R9 bytes before page end");
        rd_arr(16'h0000, 2, "R9 bytes wrapped to page start");
        rd_arr(16'h0080, 1, "R9 next page untouched");

        // R10: read wraps over array end.
        wr_arr(16'h01FE, '{8'h31, 8'h42});
        rd_arr(16'h01FE, 4, "R10 sequential read wraps");

        // R6: upper address bits are dropped.
        wr_arr(16'hFE05, '{8'hE7});
        rd_arr(16'h0005, 1, "R6 masked write address");
        rd_arr(16'h2005, 1, "R6 masked read address");

        // R5 R8: each protection setting across all quarters.
        for (int p = 1; p < 4; p++) begin
            wr_stat(8'hF3 | (p << 2));
            rd_stat(1, "R5 status write takes bits 3:2 only");
            for (int q = 0; q < 4; q++)
                wr_arr(q * (DEPTH / 4) + 16'h20 + p, '{8'h40 + p * 4 + q});
            for (int q = 0; q < 4; q++)
                rd_arr(q * (DEPTH / 4) + 16'h20 + p, 1, "R8 quarter protection");
        end
        wr_stat(8'h00);
        rd_stat(1, "R5 latch kept over status write");

        // R3 R7: clear latch.
        cmd(4);
        rd_stat(1, "R3 latch cleared");
        wr_arr(16'h0040, '{8'h99});
        rd_arr(16'h0040, 1, "R7 write rejected after clear");

        // R2: abort in the middle of a data byte.
        cmd(6);
        cs_lo();
        send_byte(2);
        send_addr(16'h0030);
        send_byte(8'hAA);
        ref_mem[16'h030] = 8'hAA;
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        cs_hi();
        chk("R2 output high after abort", int'(sdo), 1);
        rd_arr(16'h0030, 2, "R2 partial byte discarded");

        // R2: abort mid instruction, then a clean frame.
        cs_lo();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        cs_hi();
        rd_stat(1, "R2 counter cleared by abort");

        // R2 R10: output releases after a read that ended low.
        cs_lo();
        send_byte(3);
        send_addr(16'h0150);
        read_byte(v);
        chk("R10 read of zero byte", v, ref_mem[16'h150]);
        chk("R10 last bit low before abort", int'(sdo), 0);
        cs_hi();
        chk("R2 output released by chip select", int'(sdo), 1);

        // R3: unknown instruction stays idle.
        cs_lo();
        send_byte(8'h07);
        for (int i = 0; i < 8; i++) send_bit(1'b0);
        chk("R3 unknown code leaves output high", int'(sdo), 1);
        cs_hi();
        rd_stat(1, "R3 unknown code leaves status");

        // R11: hold ignores pulses, release with clock high is no edge.
        cmd(4);
        cs_lo();
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        @(negedge clk);
        hold_n = 1'b0;
        sdi = 1'b1;
        wait_n(4);
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1;
            wait_n(8);
            sclk = 1'b0;
            wait_n(8);
        end
        sclk = 1'b1;
        wait_n(8);
        hold_n = 1'b1;
        wait_n(8);
        sclk = 1'b0;
        wait_n(8);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(1'b0);
        cs_hi();
        ref_wel = 1;
        rd_stat(1, "R11 hold pulses and release ignored");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule